// File: doc/BRIEF.md
# Packed Fused Multiply-Add/Subtract Lane Controller

This block sits in front of an external packed double-precision fused multiply-add datapath. It accepts one vector operation at a time: a destination vector, a second-source vector and a third-source vector, each holding up to eight 64-bit lanes. It also takes the operation's controls: operand-order form, vector length, mask selection, zeroing flag, the shared broadcast/rounding bit, the memory-source flag and the two rounding-mode fields. For every lane it routes the right operands to the multiplicand, multiplier and addend slots. It flags whether the addend is to be negated and picks the rounding mode for the whole operation. The result is presented to the datapath through a registered valid/ready issue port.

The mask, zeroing and length controls and the old destination value travel with each operation through a small in-order control queue. When the datapath hands the lane results back, the block merges them into the destination image. Written lanes take the new result. Masked-off lanes either keep the old value or are cleared, and every lane beyond the active length is cleared. The merged vector leaves through a registered valid/ready writeback port. The block does no floating-point arithmetic itself and produces no exception flags.

Top module: `fmas_lane_ctl`

## Requirements
- R1: Vector length code 0, 1 or 2 gives 2, 4 or 8 active lanes. Lane j is bits j*64+63..j*64. On issue, inactive lanes carry zero operands and a clear bit in `iss_act`. On writeback, every inactive lane is zero.
- R2: Form code 0 issues multiplicand = destination lane, multiplier = third-source lane, addend = second-source lane.
- R3: Form code 1 issues multiplicand = second-source lane, multiplier = destination lane, addend = third-source lane.
- R4: Form code 2 issues multiplicand = second-source lane, multiplier = third-source lane, addend = destination lane.
- R5: `iss_neg[j]` is 1 (subtract the addend) for every active lane with an even index. It is 0 for odd lanes and for inactive lanes.
- R6: When the b bit and the memory flag are both 1, every lane uses bits 63..0 of the third source as its third-source value.
- R7: `iss_rc` equals the embedded rounding field only when the length code is 2, the b bit is 1 and the memory flag is 0. Otherwise it equals the global rounding field. With a register source, the b bit causes no broadcast.
- R8: Mask select 0 means no writemask, so every active lane is written whatever the mask bits hold. Mask bits at or above the active lane count have no effect.
- R9: With a non-zero mask select and zeroing flag 0, an active lane whose mask bit is 0 keeps its old destination value on writeback.
- R10: With a non-zero mask select and zeroing flag 1, an active lane whose mask bit is 0 is zero on writeback.
- R11: The issue port presents an accepted operation on the next cycle. Issue and writeback data stay stable while their valid is high and ready is low.
- R12: Returned results are paired in order with the oldest outstanding operation's controls. `ret_ready` stays low while no operation is outstanding. Writeback appears on the cycle after a return is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New operation offered |
| req_ready | output | 1 | Operation can be accepted |
| req_dest | input | 512 | Destination vector (old value) |
| req_src2 | input | 512 | Second-source vector |
| req_src3 | input | 512 | Third-source vector |
| req_form | input | 2 | Operand order: 0, 1, 2 as in R2–R4 |
| req_vlen | input | 2 | Length code: 0=128, 1=256, 2=512 bits |
| req_ksel | input | 3 | Mask register index, 0 = no mask |
| req_kmask | input | 8 | Mask bits, bit j for lane j |
| req_zero | input | 1 | 1 = zero masked-off lanes, 0 = merge |
| req_bbit | input | 1 | Broadcast (memory) or rounding override (register) |
| req_mem | input | 1 | Third source came from memory |
| req_erc | input | 2 | Embedded rounding field |
| req_grc | input | 2 | Global rounding field |
| iss_valid | output | 1 | Issue bundle valid |
| iss_ready | input | 1 | Datapath takes the bundle |
| iss_mul_a | output | 512 | Multiplicand per lane |
| iss_mul_b | output | 512 | Multiplier per lane |
| iss_addend | output | 512 | Addend per lane |
| iss_neg | output | 8 | Subtract the addend in lane j |
| iss_act | output | 8 | Lane j is within the vector length |
| iss_rc | output | 2 | Effective rounding mode |
| ret_valid | input | 1 | Datapath result valid |
| ret_ready | output | 1 | Result can be accepted |
| ret_data | input | 512 | Lane results |
| wb_valid | output | 1 | Merged destination valid |
| wb_ready | input | 1 | Consumer takes the writeback |
| wb_data | output | 512 | Merged destination vector |

## Verification
Two functions can land in the same cycle. A new operation can be accepted into the control queue while an earlier operation's results are returned and merged out of it. The bench provokes this by offering the next request and the previous results on the same clock edge. Each writeback is judged against its own operation's mask, zeroing and length settings, so any mix-up between the push and the pop shows up as wrong lanes.

// File: rtl/fmas_pkg.sv
package fmas_pkg;
  typedef enum logic [1:0] {
    FORM_132 = 2'd0,
    FORM_213 = 2'd1,
    FORM_231 = 2'd2,
    FORM_RSV = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    VL_128 = 2'd0,
    VL_256 = 2'd1,
    VL_512 = 2'd2,
    VL_RSV = 2'd3
  } vlen_e;
endpackage

// File: rtl/fmas_steer.sv
module fmas_steer
  import fmas_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int EW     = 64,
  parameter int KSEL_W = 3,
  parameter int RC_W   = 2
) (
  input  logic [LANES*EW-1:0] dest,
  input  logic [LANES*EW-1:0] src2,
  input  logic [LANES*EW-1:0] src3,
  input  form_e               form,
  input  vlen_e               vlen,
  input  logic                bbit,
  input  logic                mem,
  input  logic [RC_W-1:0]     erc,
  input  logic [RC_W-1:0]     grc,
  input  logic [KSEL_W-1:0]   ksel,
  input  logic [LANES-1:0]    kmask,
  output logic [LANES*EW-1:0] mul_a,
  output logic [LANES*EW-1:0] mul_b,
  output logic [LANES*EW-1:0] addend,
  output logic [LANES-1:0]    neg,
  output logic [LANES-1:0]    act,
  output logic [LANES-1:0]    wr_en,
  output logic [RC_W-1:0]     rc
);
  logic bcast;
  logic rc_ovr;
  logic no_mask;
  logic [31:0] kl;

  assign bcast   = bbit & mem;
  assign rc_ovr  = bbit & ~mem & vlen[1];
  assign rc      = rc_ovr ? erc : grc;
  assign no_mask = (ksel == '0);
  assign kl      = 32'd2 << vlen;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [EW-1:0] d_l, s2_l, s3_l;
    logic [EW-1:0] a_l, b_l, c_l;

    assign d_l  = dest[j*EW +: EW];
    assign s2_l = src2[j*EW +: EW];
    assign s3_l = bcast ? src3[EW-1:0] : src3[j*EW +: EW];

    assign a_l = (form == FORM_132) ? d_l : s2_l;
    assign b_l = (form == FORM_213) ? d_l : s3_l;
    assign c_l = (form == FORM_132) ? s2_l :
                 (form == FORM_213) ? s3_l : d_l;

    assign act[j]   = (32'(j) < kl);
    assign wr_en[j] = act[j] & (no_mask | kmask[j]);
    assign neg[j]   = act[j] & ((j % 2) == 0);

    assign mul_a[j*EW +: EW]  = act[j] ? a_l : '0;
    assign mul_b[j*EW +: EW]  = act[j] ? b_l : '0;
    assign addend[j*EW +: EW] = act[j] ? c_l : '0;
  end
endmodule

// File: rtl/fmas_ctl_fifo.sv
module fmas_ctl_fifo #(
  parameter int W     = 530,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign dout  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/fmas_merge.sv
module fmas_merge #(
  parameter int LANES = 8,
  parameter int EW    = 64
) (
  input  logic [LANES*EW-1:0] res,
  input  logic [LANES*EW-1:0] old,
  input  logic [LANES-1:0]    act,
  input  logic [LANES-1:0]    wr_en,
  input  logic                zero,
  output logic [LANES*EW-1:0] merged
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign merged[j*EW +: EW] =
      !act[j]  ? '0 :
      wr_en[j] ? res[j*EW +: EW] :
      zero     ? '0 : old[j*EW +: EW];
  end
endmodule

// File: rtl/fmas_lane_ctl.sv
module fmas_lane_ctl
  import fmas_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int EW     = 64,
  parameter int DEPTH  = 4,
  parameter int KSEL_W = 3,
  parameter int RC_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES*EW-1:0] req_dest,
  input  logic [LANES*EW-1:0] req_src2,
  input  logic [LANES*EW-1:0] req_src3,
  input  logic [1:0]          req_form,
  input  logic [1:0]          req_vlen,
  input  logic [KSEL_W-1:0]   req_ksel,
  input  logic [LANES-1:0]    req_kmask,
  input  logic                req_zero,
  input  logic                req_bbit,
  input  logic                req_mem,
  input  logic [RC_W-1:0]     req_erc,
  input  logic [RC_W-1:0]     req_grc,
  output logic                iss_valid,
  input  logic                iss_ready,
  output logic [LANES*EW-1:0] iss_mul_a,
  output logic [LANES*EW-1:0] iss_mul_b,
  output logic [LANES*EW-1:0] iss_addend,
  output logic [LANES-1:0]    iss_neg,
  output logic [LANES-1:0]    iss_act,
  output logic [RC_W-1:0]     iss_rc,
  input  logic                ret_valid,
  output logic                ret_ready,
  input  logic [LANES*EW-1:0] ret_data,
  output logic                wb_valid,
  input  logic                wb_ready,
  output logic [LANES*EW-1:0] wb_data
);
  localparam int VW = LANES * EW;
  localparam int QW = VW + 2 * LANES + 1;

  logic [VW-1:0]    st_a, st_b, st_c;
  logic [LANES-1:0] st_neg, st_act, st_wr;
  logic [RC_W-1:0]  st_rc;

  fmas_steer #(
    .LANES(LANES), .EW(EW), .KSEL_W(KSEL_W), .RC_W(RC_W)
  ) u_steer (
    .dest   (req_dest),
    .src2   (req_src2),
    .src3   (req_src3),
    .form   (form_e'(req_form)),
    .vlen   (vlen_e'(req_vlen)),
    .bbit   (req_bbit),
    .mem    (req_mem),
    .erc    (req_erc),
    .grc    (req_grc),
    .ksel   (req_ksel),
    .kmask  (req_kmask),
    .mul_a  (st_a),
    .mul_b  (st_b),
    .addend (st_c),
    .neg    (st_neg),
    .act    (st_act),
    .wr_en  (st_wr),
    .rc     (st_rc)
  );

  logic          q_full, q_empty;
  logic [QW-1:0] q_din, q_dout;
  logic          req_fire, ret_fire;

  assign req_ready = (!iss_valid || iss_ready) && !q_full;
  assign req_fire  = req_valid && req_ready;
  assign ret_ready = !q_empty && (!wb_valid || wb_ready);
  assign ret_fire  = ret_valid && ret_ready;
  assign q_din     = {req_zero, st_wr, st_act, req_dest};

  fmas_ctl_fifo #(.W(QW), .DEPTH(DEPTH)) u_ctlq (
    .clk   (clk),
    .rst   (rst),
    .push  (req_fire),
    .din   (q_din),
    .pop   (ret_fire),
    .dout  (q_dout),
    .full  (q_full),
    .empty (q_empty)
  );

  logic [VW-1:0] mg_data;

  fmas_merge #(.LANES(LANES), .EW(EW)) u_merge (
    .res    (ret_data),
    .old    (q_dout[VW-1:0]),
    .act    (q_dout[VW +: LANES]),
    .wr_en  (q_dout[VW+LANES +: LANES]),
    .zero   (q_dout[QW-1]),
    .merged (mg_data)
  );

  // issue register
  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= 1'b0;
    end else if (req_fire) begin
      iss_valid <= 1'b1;
    end else if (iss_ready) begin
      iss_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (req_fire) begin
      iss_mul_a  <= st_a;
      iss_mul_b  <= st_b;
      iss_addend <= st_c;
      iss_neg    <= st_neg;
      iss_act    <= st_act;
      iss_rc     <= st_rc;
    end
  end

  // writeback register
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
    end else if (ret_fire) begin
      wb_valid <= 1'b1;
    end else if (wb_ready) begin
      wb_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ret_fire) wb_data <= mg_data;
  end
endmodule

// File: rtl/fmas_lane_ctl_chk.sv
module fmas_lane_ctl_chk #(
  parameter int LANES = 8,
  parameter int EW    = 64,
  parameter int RC_W  = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_ready,
  input logic                iss_valid,
  input logic                iss_ready,
  input logic [LANES*EW-1:0] iss_mul_a,
  input logic [LANES*EW-1:0] iss_mul_b,
  input logic [LANES*EW-1:0] iss_addend,
  input logic [LANES-1:0]    iss_neg,
  input logic [LANES-1:0]    iss_act,
  input logic [RC_W-1:0]     iss_rc,
  input logic                ret_valid,
  input logic                ret_ready,
  input logic                wb_valid,
  input logic                wb_ready,
  input logic [LANES*EW-1:0] wb_data
);
  logic [7:0] outstanding;

  always_ff @(posedge clk) begin
    if (rst) outstanding <= '0;
    else outstanding <= outstanding + 8'(req_valid && req_ready)
                                    - 8'(ret_valid && ret_ready);
  end

  AST_ISS_HOLD: assert property (@(posedge clk) disable iff (rst)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss_mul_a)
      && $stable(iss_mul_b) && $stable(iss_addend) && $stable(iss_rc)); // R11

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_data)); // R11

  AST_ISS_NEXT: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> iss_valid); // R11

  AST_RET_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    ret_ready |-> outstanding != 8'd0); // R12

  AST_WB_AFTER_RET: assert property (@(posedge clk) disable iff (rst)
    ret_valid && ret_ready |=> wb_valid); // R12

  AST_NEG_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> (iss_neg & ~iss_act) == '0); // R5

  AST_ACT_PREFIX: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> iss_act[1:0] == 2'b11
      && $onehot0({1'b0, iss_act} + 1'b1)); // R1
endmodule

bind fmas_lane_ctl fmas_lane_ctl_chk #(.LANES(LANES), .EW(EW), .RC_W(RC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .iss_valid  (iss_valid),
  .iss_ready  (iss_ready),
  .iss_mul_a  (iss_mul_a),
  .iss_mul_b  (iss_mul_b),
  .iss_addend (iss_addend),
  .iss_neg    (iss_neg),
  .iss_act    (iss_act),
  .iss_rc     (iss_rc),
  .ret_valid  (ret_valid),
  .ret_ready  (ret_ready),
  .wb_valid   (wb_valid),
  .wb_ready   (wb_ready),
  .wb_data    (wb_data)
);

// File: tb/fmas_lane_ctl_tb.sv
module fmas_lane_ctl_tb;
  localparam int L  = 8;
  localparam int VW = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          req_valid = 0, iss_ready = 0, ret_valid = 0, wb_ready = 0;
  logic          req_ready, iss_valid, ret_ready, wb_valid;
  logic [VW-1:0] req_dest = '0, req_src2 = '0, req_src3 = '0, ret_data = '0;
  logic [1:0]    req_form = 0, req_vlen = 0, req_erc = 0, req_grc = 0;
  logic [2:0]    req_ksel = 0;
  logic [L-1:0]  req_kmask = 0;
  logic          req_zero = 0, req_bbit = 0, req_mem = 0;
  logic [VW-1:0] iss_mul_a, iss_mul_b, iss_addend, wb_data;
  logic [L-1:0]  iss_neg, iss_act;
  logic [1:0]    iss_rc;

  int errors = 0;
  int checks = 0;

  fmas_lane_ctl u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_dest(req_dest), .req_src2(req_src2), .req_src3(req_src3),
    .req_form(req_form), .req_vlen(req_vlen), .req_ksel(req_ksel),
    .req_kmask(req_kmask), .req_zero(req_zero), .req_bbit(req_bbit),
    .req_mem(req_mem), .req_erc(req_erc), .req_grc(req_grc),
    .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_mul_a(iss_mul_a), .iss_mul_b(iss_mul_b), .iss_addend(iss_addend),
    .iss_neg(iss_neg), .iss_act(iss_act), .iss_rc(iss_rc),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_data(ret_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data)
  );

  task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] mkvec(input logic [7:0] tagb, input logic [7:0] seed);
    logic [VW-1:0] v;
    for (int j = 0; j < L; j++) v[j*64 +: 64] = {tagb, 40'h0, seed, 8'(j)};
    return v;
  endfunction

  // bench model from the requirements
  logic [VW-1:0] e_a, e_b, e_c, e_wb;
  logic [L-1:0]  e_neg, e_act;
  logic [1:0]    e_rc;

  task automatic model();
    int kl;
    kl = 2 << req_vlen;
    e_rc = (req_vlen == 2 && req_bbit && !req_mem) ? req_erc : req_grc;
    for (int j = 0; j < L; j++) begin
      logic [63:0] d, s2, s3, r;
      logic on, wr;
      d  = req_dest[j*64 +: 64];
      s2 = req_src2[j*64 +: 64];
      s3 = (req_bbit && req_mem) ? req_src3[63:0] : req_src3[j*64 +: 64];
      r  = ret_data[j*64 +: 64];
      on = (j < kl);
      wr = (req_ksel == 0) || req_kmask[j];
      e_act[j] = on;
      e_neg[j] = on && (j % 2 == 0);
      case (req_form)
        2'd0:    begin e_a[j*64+:64] = d;  e_b[j*64+:64] = s3; e_c[j*64+:64] = s2; end
        2'd1:    begin e_a[j*64+:64] = s2; e_b[j*64+:64] = d;  e_c[j*64+:64] = s3; end
        default: begin e_a[j*64+:64] = s2; e_b[j*64+:64] = s3; e_c[j*64+:64] = d;  end
      endcase
      if (!on) begin
        e_a[j*64+:64] = '0; e_b[j*64+:64] = '0; e_c[j*64+:64] = '0;
      end
      e_wb[j*64+:64] = !on ? 64'h0 : wr ? r : req_zero ? 64'h0 : d;
    end
  endtask

  task automatic setup(input logic [1:0] f, input logic [1:0] vl, input logic [2:0] ks,
                       input logic [7:0] km, input logic z, input logic b, input logic m,
                       input logic [1:0] erc, input logic [1:0] grc, input logic [7:0] seed);
    req_form = f; req_vlen = vl; req_ksel = ks; req_kmask = km; req_zero = z;
    req_bbit = b; req_mem = m; req_erc = erc; req_grc = grc;
    req_dest = mkvec(8'hD0, seed);
    req_src2 = mkvec(8'hB0, seed);
    req_src3 = mkvec(8'hC0, seed);
    ret_data = mkvec(8'hE0, seed);
  endtask

  task automatic send_req();
    req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic check_issue(input string tag);
    chk({tag, " issue valid"}, VW'(iss_valid), VW'(1));
    chk({tag, " mul_a"}, iss_mul_a, e_a);
    chk({tag, " mul_b"}, iss_mul_b, e_b);
    chk({tag, " addend"}, iss_addend, e_c);
    chk({tag, " neg R5"}, VW'(iss_neg), VW'(e_neg));
    chk({tag, " act R1"}, VW'(iss_act), VW'(e_act));
    chk({tag, " rc R7"}, VW'(iss_rc), VW'(e_rc));
  endtask

  task automatic take_issue();
    iss_ready = 1; @(negedge clk); iss_ready = 0;
  endtask

  task automatic do_return(input string tag);
    ret_valid = 1;
    while (!ret_ready) @(negedge clk);
    @(negedge clk);
    ret_valid = 0;
    chk({tag, " wb valid R12"}, VW'(wb_valid), VW'(1));
    chk({tag, " wb data"}, wb_data, e_wb);
    wb_ready = 1; @(negedge clk); wb_ready = 0;
  endtask

  task automatic run_op(input string tag);
    model();
    send_req();
    check_issue(tag);
    take_issue();
    do_return(tag);
  endtask

  task automatic t_reset();
    chk("R11 reset iss_valid", VW'(iss_valid), VW'(0));
    chk("R12 reset wb_valid", VW'(wb_valid), VW'(0));
    chk("R12 reset ret_ready", VW'(ret_ready), VW'(0));
    chk("R11 reset req_ready", VW'(req_ready), VW'(1));
  endtask

  task automatic t_form132();
    setup(0, 2, 0, 8'h00, 0, 0, 0, 2'd3, 2'd1, 8'h01);
    run_op("R2 form132 len512");
  endtask

  task automatic t_form213();
    setup(1, 1, 0, 8'h00, 1, 0, 0, 2'd2, 2'd0, 8'h02);
    run_op("R3 R8 form213 len256 nomask");
  endtask

  task automatic t_form231();
    setup(2, 0, 0, 8'h00, 0, 0, 0, 2'd1, 2'd2, 8'h03);
    run_op("R4 R1 form231 len128");
  endtask

  task automatic t_bcast();
    setup(1, 2, 0, 8'h00, 0, 1, 1, 2'd3, 2'd1, 8'h04);
    run_op("R6 broadcast mem");
  endtask

  task automatic t_rc_ovr();
    setup(2, 2, 0, 8'h00, 0, 1, 0, 2'd2, 2'd1, 8'h05);
    run_op("R7 override reg 512");
  endtask

  task automatic t_rc_256();
    setup(0, 1, 0, 8'h00, 0, 1, 0, 2'd2, 2'd1, 8'h06);
    run_op("R7 no override 256");
  endtask

  task automatic t_merge();
    setup(0, 2, 3'd1, 8'b1010_0110, 0, 0, 0, 2'd0, 2'd3, 8'h07);
    run_op("R9 merge mask");
  endtask

  task automatic t_zero();
    setup(2, 1, 3'd5, 8'b1111_0101, 1, 0, 0, 2'd0, 2'd2, 8'h08);
    run_op("R10 R8 zero mask high bits");
  endtask

  task automatic t_stall();
    logic [VW-1:0] hold_a, hold_wb;
    setup(1, 2, 3'd2, 8'b0011_1100, 0, 0, 0, 2'd1, 2'd2, 8'h09);
    model();
    send_req();
    hold_a = iss_mul_a;
    repeat (3) @(negedge clk);
    chk("R11 issue held valid", VW'(iss_valid), VW'(1));
    chk("R11 issue held data", iss_mul_a, hold_a);
    check_issue("R11 stall");
    take_issue();
    ret_valid = 1;
    while (!ret_ready) @(negedge clk);
    @(negedge clk);
    ret_valid = 0;
    hold_wb = wb_data;
    repeat (3) @(negedge clk);
    chk("R11 wb held valid", VW'(wb_valid), VW'(1));
    chk("R11 wb held data", wb_data, hold_wb);
    chk("R9 stall wb data", wb_data, e_wb);
    wb_ready = 1; @(negedge clk); wb_ready = 0;
  endtask

  task automatic t_overlap();
    logic [VW-1:0] wb_a_exp;
    setup(0, 2, 3'd1, 8'b0101_0101, 1, 0, 0, 2'd0, 2'd1, 8'h0A);
    model();
    wb_a_exp = e_wb;
    send_req();
    take_issue();
    // new request B and return for A on the same edge
    setup(2, 1, 3'd4, 8'b0000_1010, 0, 0, 0, 2'd0, 2'd2, 8'h0B);
    ret_data = mkvec(8'hE0, 8'h0A);
    model();
    req_valid = 1; ret_valid = 1;
    chk("R12 both ready", VW'({req_ready, ret_ready}), VW'(2'b11));
    @(negedge clk);
    req_valid = 0; ret_valid = 0;
    chk("R12 overlap wb of first", wb_data, wb_a_exp);
    check_issue("R12 overlap second");
    wb_ready = 1; iss_ready = 1; @(negedge clk); wb_ready = 0; iss_ready = 0;
    ret_data = mkvec(8'hE0, 8'h0B);
    model();
    do_return("R12 overlap second");
    chk("R12 no outstanding", VW'(ret_ready), VW'(0));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_form132();
    t_form213();
    t_form231();
    t_bcast();
    t_rc_ovr();
    t_rc_256();
    t_merge();
    t_zero();
    t_stall();
    t_overlap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule